// File: doc/BRIEF.md
# Timer tick generator

This block turns one 8-bit control register into count-enable pulses for four timers. Timers 0 and 1 share a prescaled tick. That tick comes from a free-running divider that divides the system clock by 12, 4 or 48. It can also come from an external clock: the block synchronises it into the system clock domain and divides its rising edges by 8. A per-timer select bit can replace the shared tick with a pulse on every system clock. A timer that is set to count external events gets no tick from this block.

Timers 2 and 3 each have a low and a high half. Each half gets either the system clock rate or an alternate tick that the timer's own control logic has already chosen. The high-half select bit counts only when the timer is split into two 8-bit halves. In any other mode the high half copies the low half's choice. Every output is a single-cycle enable in the system clock domain, not a derived clock.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset the register reads 0x00. Timers 0 and 1 then receive one tick every 12 system clocks.
- R2: A write with `cfg_we` high stores `cfg_wdata`. From the next cycle `cfg_rdata` returns that value.
- R3: Register bits [1:0] select the prescale code. With a timer's select bit at 0, code 00 gives one tick per 12 cycles, 01 gives one per 4 and 10 gives one per 48. Each tick lasts one cycle.
- R4: Prescale code 11 gives one single-cycle tick for every 8 rising edges of `ext_clk`. The external clock must be slower than half the system clock.
- R5: A write that changes bits [1:0] to code 00, 01 or 10 restarts the divider. The first prescaled tick then appears N cycles after the writing edge, where N is the new division ratio.
- R6: Bit 2 (timer 0) and bit 3 (timer 1) set to 1 make that timer tick on every system clock.
- R7: While `t0_evt_mode` or `t1_evt_mode` is 1, that timer's tick stays 0 whatever its select bit is.
- R8: Bit 4 (timer 2) and bit 6 (timer 3) pick the low-half source: 1 gives a tick every cycle, 0 passes that timer's alternate tick input through.
- R9: With the split flag at 1, bit 5 (timer 2) and bit 7 (timer 3) pick the high-half source with the same encoding. With the split flag at 0 those bits are ignored and the high tick equals the low tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| ext_clk | input | 1 | Asynchronous external clock |
| t0_evt_mode | input | 1 | Timer 0 counts external events |
| t1_evt_mode | input | 1 | Timer 1 counts external events |
| t2_split | input | 1 | Timer 2 runs as two 8-bit halves |
| t3_split | input | 1 | Timer 3 runs as two 8-bit halves |
| t2_alt_tick | input | 1 | Timer 2 alternate tick |
| t3_alt_tick | input | 1 | Timer 3 alternate tick |
| t0_tick | output | 1 | Timer 0 count enable |
| t1_tick | output | 1 | Timer 1 count enable |
| t2_lo_tick | output | 1 | Timer 2 low-half count enable |
| t2_hi_tick | output | 1 | Timer 2 high-half count enable |
| t3_lo_tick | output | 1 | Timer 3 low-half count enable |
| t3_hi_tick | output | 1 | Timer 3 high-half count enable |

## Verification
Each register value is held for a 480-cycle window, and the pulses on all six outputs are counted. Because 480 is a multiple of every period in use, the counts separate the four prescale codes from one another and from the every-cycle rate. The alternate ticks repeat every 3 and every 5 cycles, so a passed-through alternate tick cannot be confused with a prescaled tick or with the every-cycle rate. The high-half select bits are tried with the split flag both off and on, which shows whether they are ignored or obeyed. After each code change the position of the first timer 0 tick is recorded, which shows whether the divider restarted or carried a stale count.

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_C0 = 12,
  parameter int DIV_C1 = 4,
  parameter int DIV_C2 = 48,
  parameter int EXT_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       ext_clk,
  input  logic       t0_evt_mode,
  input  logic       t1_evt_mode,
  input  logic       t2_split,
  input  logic       t3_split,
  input  logic       t2_alt_tick,
  input  logic       t3_alt_tick,
  output logic       t0_tick,
  output logic       t1_tick,
  output logic       t2_lo_tick,
  output logic       t2_hi_tick,
  output logic       t3_lo_tick,
  output logic       t3_hi_tick
);
  localparam int DMAX = (DIV_C0 > DIV_C1) ? ((DIV_C0 > DIV_C2) ? DIV_C0 : DIV_C2)
                                          : ((DIV_C1 > DIV_C2) ? DIV_C1 : DIV_C2);
  localparam int CW = $clog2(DMAX);
  localparam int EW = $clog2(EXT_DIV);
  localparam logic [CW-1:0] LAST0 = CW'(DIV_C0 - 1);
  localparam logic [CW-1:0] LAST1 = CW'(DIV_C1 - 1);
  localparam logic [CW-1:0] LAST2 = CW'(DIV_C2 - 1);
  localparam logic [EW-1:0] ELAST = EW'(EXT_DIV - 1);

  logic [7:0]    cfg;
  logic [CW-1:0] div_cnt, div_last;
  logic [2:0]    ext_sync;
  logic [EW-1:0] ext_cnt;
  logic          ext_tick, ext_rise, pre_tick, code_chg;

  assign cfg_rdata = cfg;
  assign code_chg  = cfg_we && (cfg_wdata[1:0] != cfg[1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= cfg_wdata;

  always_comb
    case (cfg[1:0])
      2'b01:   div_last = LAST1;
      2'b10:   div_last = LAST2;
      default: div_last = LAST0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    div_cnt <= '0;
    else if (code_chg)             div_cnt <= '0;
    else if (div_cnt == div_last)  div_cnt <= '0;
    else                           div_cnt <= div_cnt + 1'b1;

  assign ext_rise = ext_sync[1] & ~ext_sync[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_sync <= '0;
      ext_cnt  <= '0;
      ext_tick <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_clk};
      ext_tick <= ext_rise && (ext_cnt == ELAST);
      if (ext_rise) ext_cnt <= (ext_cnt == ELAST) ? '0 : ext_cnt + 1'b1;
    end

  assign pre_tick   = (cfg[1:0] == 2'b11) ? ext_tick : (div_cnt == div_last);
  assign t0_tick    = !t0_evt_mode && (cfg[2] || pre_tick);
  assign t1_tick    = !t1_evt_mode && (cfg[3] || pre_tick);
  assign t2_lo_tick = cfg[4] || t2_alt_tick;
  assign t2_hi_tick = (t2_split ? cfg[5] : cfg[4]) || t2_alt_tick;
  assign t3_lo_tick = cfg[6] || t3_alt_tick;
  assign t3_hi_tick = (t3_split ? cfg[7] : cfg[6]) || t3_alt_tick;
endmodule

// File: rtl/tmr_tick_gen_chk.sv
module tmr_tick_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       t0_evt_mode,
  input logic       t1_evt_mode,
  input logic       t2_split,
  input logic       t3_split,
  input logic       t0_tick,
  input logic       t1_tick,
  input logic       t2_lo_tick,
  input logic       t2_hi_tick,
  input logic       t3_lo_tick,
  input logic       t3_hi_tick
);
  assert_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_tick && !cfg_we && !cfg_rdata[2]) |=> !t0_tick);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1:0] != cfg_rdata[1:0] && cfg_wdata[1:0] != 2'b11 && !cfg_wdata[2])
      |=> !t0_tick);

  assert_sys_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && !t1_evt_mode) |-> t1_tick);

  assert_evt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_evt_mode |-> !t0_tick) and (t1_evt_mode |-> !t1_tick));

  assert_lo_sys_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4] |-> t2_lo_tick) and (cfg_rdata[6] |-> t3_lo_tick));

  assert_hi_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!t2_split |-> t2_hi_tick == t2_lo_tick) and (!t3_split |-> t3_hi_tick == t3_lo_tick));
endmodule

bind tmr_tick_gen tmr_tick_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .t0_evt_mode(t0_evt_mode), .t1_evt_mode(t1_evt_mode), .t2_split(t2_split), .t3_split(t3_split),
  .t0_tick(t0_tick), .t1_tick(t1_tick), .t2_lo_tick(t2_lo_tick), .t2_hi_tick(t2_hi_tick),
  .t3_lo_tick(t3_lo_tick), .t3_hi_tick(t3_hi_tick)
);

// File: tb/tmr_tick_gen_bench.sv
module tmr_tick_gen_bench;
  localparam int WIN = 480;

  logic clk = 0, rst_n = 0, cfg_we = 0, ext_clk = 0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic t0_evt_mode = 0, t1_evt_mode = 0, t2_split = 0, t3_split = 0;
  logic t2_alt_tick = 0, t3_alt_tick = 0;
  logic t0_tick, t1_tick, t2_lo_tick, t2_hi_tick, t3_lo_tick, t3_hi_tick;

  typedef struct {
    string req;
    int    rd;
    int    cnt[6];
    int    first;
  } item_t;
  item_t q[$];
  event go, done;
  int vectors = 0, miscompares = 0, c2 = 0, c3 = 0;

  tmr_tick_gen u_tmr_tick_gen (.*);

  always #4 clk = ~clk;
  initial begin #3; forever #40 ext_clk = ~ext_clk; end

  always @(posedge clk) begin
    #2;
    t2_alt_tick = (c2 == 0);
    t3_alt_tick = (c3 == 0);
    c2 = (c2 + 1) % 3;
    c3 = (c3 + 1) % 5;
  end

  task automatic check(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run(string req, bit wr, logic [7:0] val, bit e0, bit e1, bit s2, bit s3,
                     int n0, int n1, int n2l, int n2h, int n3l, int n3h, int first);
    item_t it;
    it.req = req; it.rd = val;
    it.cnt = '{n0, n1, n2l, n2h, n3l, n3h};
    it.first = first;
    q.push_back(it);
    t0_evt_mode = e0; t1_evt_mode = e1; t2_split = s2; t3_split = s3;
    cfg_we = wr; cfg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    -> go;
    @(done);
  endtask

  initial begin
    item_t it;
    int cnt[6];
    int first;
    forever begin
      @(go);
      it = q.pop_front();
      cnt = '{0, 0, 0, 0, 0, 0};
      first = -1;
      check(it.req, "read data", int'(cfg_rdata), it.rd);
      for (int i = 0; i < WIN; i++) begin
        if (t0_tick && first < 0) first = i;
        cnt[0] += int'(t0_tick);    cnt[1] += int'(t1_tick);
        cnt[2] += int'(t2_lo_tick); cnt[3] += int'(t2_hi_tick);
        cnt[4] += int'(t3_lo_tick); cnt[5] += int'(t3_hi_tick);
        @(negedge clk);
      end
      check(it.req, "t0 ticks", cnt[0], it.cnt[0]);
      check(it.req, "t1 ticks", cnt[1], it.cnt[1]);
      check(it.req, "t2 low ticks", cnt[2], it.cnt[2]);
      check(it.req, "t2 high ticks", cnt[3], it.cnt[3]);
      check(it.req, "t3 low ticks", cnt[4], it.cnt[4]);
      check(it.req, "t3 high ticks", cnt[5], it.cnt[5]);
      if (it.first >= 0) check("R5", "first t0 tick index", first, it.first);
      -> done;
    end
  end

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run("R1", 0, 8'h00, 0, 0, 0, 0, 40, 40, 160, 160, 96, 96, -1);
    run("R3", 1, 8'h01, 0, 0, 0, 0, 120, 120, 160, 160, 96, 96, 3);
    run("R3", 1, 8'h02, 0, 0, 0, 0, 10, 10, 160, 160, 96, 96, 47);
    run("R2", 1, 8'h00, 0, 0, 0, 0, 40, 40, 160, 160, 96, 96, 11);
    run("R4", 1, 8'h03, 0, 0, 0, 0, 6, 6, 160, 160, 96, 96, -1);
    run("R6", 1, 8'h06, 0, 0, 0, 0, 480, 10, 160, 160, 96, 96, -1);
    run("R6", 1, 8'h09, 0, 0, 0, 0, 120, 480, 160, 160, 96, 96, 3);
    run("R7", 1, 8'h0C, 1, 1, 0, 0, 0, 0, 160, 160, 96, 96, -1);
    run("R7", 1, 8'h00, 1, 0, 0, 0, 0, 40, 160, 160, 96, 96, -1);
    run("R8", 1, 8'h50, 0, 0, 0, 0, 40, 40, 480, 480, 480, 480, -1);
    run("R9", 1, 8'hA0, 0, 0, 0, 0, 40, 40, 160, 160, 96, 96, -1);
    run("R9", 1, 8'hA0, 0, 0, 1, 1, 40, 40, 160, 480, 96, 480, -1);
    run("R9", 1, 8'h50, 0, 0, 1, 1, 40, 40, 480, 160, 480, 96, -1);
    run("R8", 1, 8'h10, 0, 0, 0, 1, 40, 40, 480, 480, 96, 96, -1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule